// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs the read side of a clocked NOR-style memory interface. When chip select and the address strobe are both low at an active clock edge, it captures a start address. It then counts a programmable initial latency and streams 16-bit array words, one word per data slot. Each word stays on the output for one or two clock cycles. The address advances either straight up or wrapped inside an aligned block whose size is the burst length. A WAIT indicator marks every cycle in which an open burst is not presenting valid data.

A 16-bit configuration word sets the burst length, the wrap mode, the latency, the hold time, the WAIT polarity and which clock edge is active. The array sits behind a synchronous read port. When `mem_rd` is high at an active edge, the array registers the word at `mem_addr` onto `mem_rdata`. Otherwise `mem_rdata` keeps its last value, and this register also serves as the output data register. Output data is a valid-only stream with no ready input. A consumer applies back-pressure by pulling `clk_en` low, which models a stopped clock, and may raise `oe_n` to release the bus. The burst then picks up at the exact word where it paused.

Burst mode reads the array only. Status and identification reads use single-word accesses outside this block.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset no burst is open: `dout_vld` and `mem_rd` are 0 and WAIT is at its inactive level.
- R2: An active edge with `ce_n`=0 and `le_n`=0 latches `addr_in`. The first word is valid right after the latency-th following active edge. The latency is `cfg_word[13:11]`, with codes 0 and 1 treated as 2. WAIT is active throughout the latency.
- R3: `cfg_word[2:0]` sets the length: 001 gives 4 words, 010 gives 8 and 011 gives 16. Every other code means continuous. After the last word of a fixed-length burst, `dout_vld` falls and WAIT stays active.
- R4: With `cfg_word[3]`=0 the address increments within the aligned block of burst length and wraps inside it. With `cfg_word[3]`=1 it increments linearly. An aligned start gives the same sequence in both modes.
- R5: `cfg_word[9]`=1 holds each word for two cycles; 0 holds it for one.
- R6: In continuous mode, one WAIT cycle with no valid data is inserted the first time the next address is a multiple of 16. No further insertion happens in that burst.
- R7: `cfg_word[10]`=1 makes WAIT active high; 0 makes it active low.
- R8: `cfg_word[6]`=1 makes rising edges of `clk` active; 0 makes falling edges active.
- R9: While `clk_en` is 0, the position, latency count, output data and `dout_vld` state are frozen and `mem_rd` is 0. Raising `clk_en` resumes from the same word or latency step, and this works during the latency or during the data phase.
- R10: While `oe_n` is 1, `dout_vld` is 0 and `dout` is 0, but the burst keeps advancing.
- R11: An active edge with `ce_n`=1 closes the burst, so WAIT goes inactive and `dout_vld` goes low.
- R12: `mem_rd` is high in the cycle before each word appears, with `mem_addr` equal to that word's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock running; 0 models a halted clock |
| cfg_word | input | 16 | Burst configuration |
| ce_n | input | 1 | Chip select, active low |
| le_n | input | 1 | Address strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | 16 | Start address |
| mem_rd | output | 1 | Array read request |
| mem_addr | output | 16 | Array read address |
| mem_rdata | input | 16 | Array registered read data |
| dout | output | 16 | Output word |
| dout_vld | output | 1 | Output word valid |
| wait_o | output | 1 | WAIT indicator, polarity per configuration |

## Verification
Bursts are started at unaligned, aligned and block-edge addresses under every length code, including an unused code. This separates wrapped order from linear order, and it shows that an aligned start makes the two modes identical. Continuous bursts that begin just below and exactly on a 16-word boundary show whether the single inserted wait cycle lands at the first crossing only. Two-cycle hold, low WAIT polarity, falling-edge clocking and a sub-minimum latency code each appear in their own vector. Directed runs pause the clock during the latency and during the data phase, and hide data with `oe_n`, to tell a true freeze apart from output masking.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

  localparam int CFG_LEN_LSB   = 0;
  localparam int CFG_LINEAR    = 3;
  localparam int CFG_EDGE      = 6;
  localparam int CFG_HOLD      = 9;
  localparam int CFG_WPOL      = 10;
  localparam int CFG_LAT_LSB   = 11;
  localparam int LAT_MIN       = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_DATA,
    ST_GAP,
    ST_DONE
  } seq_st_e;

  typedef struct packed {
    logic       cont;
    logic [2:0] len_log2;
    logic       wrap;
    logic       hold2;
    logic       wait_hi;
    logic       rise;
    logic [2:0] lat;
  } rd_cfg_t;

endpackage

// File: rtl/burst_cfg_dec.sv
module burst_cfg_dec
  import burst_rd_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic [CFG_W-1:0] cfg_word,
  output rd_cfg_t          dcfg
);

  logic [2:0] len_code;
  logic [2:0] lat_code;
  logic       unused_cfg_bits;

  assign len_code = cfg_word[CFG_LEN_LSB +: 3];
  assign lat_code = cfg_word[CFG_LAT_LSB +: 3];
  assign unused_cfg_bits = ^{cfg_word[CFG_W-1:CFG_LAT_LSB+3], cfg_word[8:7], cfg_word[5:4]};

  always_comb begin
    dcfg          = '0;
    dcfg.wrap     = ~cfg_word[CFG_LINEAR];
    dcfg.hold2    = cfg_word[CFG_HOLD];
    dcfg.wait_hi  = cfg_word[CFG_WPOL];
    dcfg.rise     = cfg_word[CFG_EDGE];
    dcfg.lat      = (lat_code < 3'(LAT_MIN)) ? 3'(LAT_MIN) : lat_code;
    unique case (len_code)
      3'b001:  begin dcfg.cont = 1'b0; dcfg.len_log2 = 3'd2; end
      3'b010:  begin dcfg.cont = 1'b0; dcfg.len_log2 = 3'd3; end
      3'b011:  begin dcfg.cont = 1'b0; dcfg.len_log2 = 3'd4; end
      default: begin dcfg.cont = 1'b1; dcfg.len_log2 = 3'd4; end
    endcase
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    len_log2,
  input  logic          wrap_en,
  output logic [AW-1:0] nxt,
  output logic          on_blk16
);

  logic [AW-1:0] low_mask;
  logic [AW-1:0] inc;

  assign low_mask = ~({AW{1'b1}} << len_log2);
  assign inc      = cur + AW'(1);
  assign nxt      = wrap_en ? ((cur & ~low_mask) | (inc & low_mask)) : inc;
  assign on_blk16 = (nxt[3:0] == 4'd0);

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_rd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ce_n,
  input  logic             le_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr_in,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    dout,
  output logic             dout_vld,
  output logic             wait_o
);

  localparam int WCNT_W = 5;

  rd_cfg_t     dcfg;
  logic        core_clk;
  seq_st_e     st_q;
  logic [AW-1:0] addr_q;
  logic [2:0]  lat_q;
  logic [WCNT_W-1:0] words_q;
  logic        hold_q;
  logic        vld_q;
  logic        crossed_q;

  logic [AW-1:0] nxt_addr;
  logic        nxt_blk16;
  logic        wrap_en;
  logic [WCNT_W-1:0] burst_words;
  logic        hold_last;
  logic        last_word;
  logic        gap_next;
  logic        advance;
  logic        wait_act;
  logic        seq_go;

  burst_cfg_dec #(.CFG_W(CFG_W)) u_dec (
    .cfg_word (cfg_word),
    .dcfg     (dcfg)
  );

  assign wrap_en = dcfg.wrap & ~dcfg.cont;

  burst_addr_step #(.AW(AW)) u_step (
    .cur      (addr_q),
    .len_log2 (dcfg.len_log2),
    .wrap_en  (wrap_en),
    .nxt      (nxt_addr),
    .on_blk16 (nxt_blk16)
  );

  // active edge chosen by configuration
  assign core_clk = dcfg.rise ? clk : ~clk;

  assign burst_words = WCNT_W'(1) << dcfg.len_log2;
  assign hold_last   = ~dcfg.hold2 | hold_q;
  assign last_word   = ~dcfg.cont & (words_q == burst_words);
  assign gap_next    = dcfg.cont & ~crossed_q & nxt_blk16;
  assign advance     = (st_q == ST_DATA) & hold_last & ~last_word & ~gap_next;
  assign seq_go      = clk_en & ~ce_n & le_n;

  // fetch request: array registers the word at the next active edge
  always_comb begin
    mem_addr = addr_q;
    mem_rd   = 1'b0;
    unique case (st_q)
      ST_LAT:  mem_rd = (lat_q == dcfg.lat);
      ST_GAP:  mem_rd = 1'b1;
      ST_DATA: begin
        mem_rd = advance;
        if (advance) mem_addr = nxt_addr;
      end
      default: mem_rd = 1'b0;
    endcase
    mem_rd = mem_rd & seq_go;
  end

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      lat_q     <= '0;
      words_q   <= '0;
      hold_q    <= 1'b0;
      vld_q     <= 1'b0;
      crossed_q <= 1'b0;
    end else if (clk_en) begin
      if (ce_n) begin
        st_q  <= ST_IDLE;
        vld_q <= 1'b0;
      end else if (!le_n) begin
        st_q      <= ST_LAT;
        addr_q    <= addr_in;
        lat_q     <= 3'd1;
        words_q   <= '0;
        hold_q    <= 1'b0;
        vld_q     <= 1'b0;
        crossed_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_LAT: begin
            if (lat_q == dcfg.lat) begin
              st_q    <= ST_DATA;
              vld_q   <= 1'b1;
              words_q <= WCNT_W'(1);
              hold_q  <= 1'b0;
            end else begin
              lat_q <= lat_q + 3'd1;
            end
          end
          ST_DATA: begin
            if (!hold_last) begin
              hold_q <= 1'b1;
            end else begin
              hold_q <= 1'b0;
              if (last_word) begin
                st_q  <= ST_DONE;
                vld_q <= 1'b0;
              end else if (gap_next) begin
                st_q      <= ST_GAP;
                vld_q     <= 1'b0;
                addr_q    <= nxt_addr;
                crossed_q <= 1'b1;
              end else begin
                addr_q  <= nxt_addr;
                words_q <= words_q + WCNT_W'(1);
              end
            end
          end
          ST_GAP: begin
            st_q    <= ST_DATA;
            vld_q   <= 1'b1;
            hold_q  <= 1'b0;
            words_q <= words_q + WCNT_W'(1);
          end
          default: st_q <= st_q;
        endcase
      end
    end
  end

  assign wait_act = (st_q != ST_IDLE) & ~vld_q;
  assign wait_o   = dcfg.wait_hi ? wait_act : ~wait_act;
  assign dout     = oe_n ? '0 : mem_rdata;
  assign dout_vld = vld_q & ~oe_n;

  AST_LAT_TO_DATA: assert property (@(posedge core_clk) disable iff (!rst_n)
    (seq_go && st_q == ST_LAT && lat_q == dcfg.lat) |=> (vld_q && st_q == ST_DATA)); // R2

  AST_DONE_NO_DATA: assert property (@(posedge core_clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> !vld_q); // R3

  AST_WRAP_IN_BLOCK: assert property (@(posedge core_clk) disable iff (!rst_n)
    (seq_go && advance && wrap_en) |=> ((addr_q >> dcfg.len_log2) == ($past(addr_q) >> dcfg.len_log2))); // R4

  AST_HOLD_TWO: assert property (@(posedge core_clk) disable iff (!rst_n)
    (seq_go && st_q == ST_DATA && dcfg.hold2 && !hold_q) |=> ($stable(addr_q) && vld_q)); // R5

  AST_GAP_SINGLE: assert property (@(posedge core_clk) disable iff (!rst_n)
    (seq_go && st_q == ST_GAP) |=> (st_q == ST_DATA && vld_q)); // R6

  AST_FREEZE: assert property (@(posedge core_clk) disable iff (!rst_n)
    !clk_en |=> ($stable(addr_q) && $stable(st_q) && $stable(vld_q) && $stable(lat_q))); // R9

  AST_CE_IDLE: assert property (@(posedge core_clk) disable iff (!rst_n)
    (clk_en && ce_n) |=> (st_q == ST_IDLE && !vld_q)); // R11

endmodule

// File: tb/burst_rd_seq_bench.sv
`timescale 1ns/1ps
module burst_rd_seq_bench;

  localparam int NSTEP = 44;
  localparam int NVEC  = 9;

  // {lat[2:0], wait_hi, hold2, rise, linear, len[2:0], start[15:0]}
  localparam logic [25:0] VEC [0:NVEC-1] = '{
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001, 16'h0006},
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'b001, 16'h0006},
    {3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 3'b010, 16'h0013},
    {3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 3'b011, 16'h002A},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 16'h003C},
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 16'h0000},
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 3'b010, 16'h0005},
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'b010, 16'h0018},
    {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001, 16'h0070}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en;
  logic [15:0] cfg_word;
  logic        ce_n, le_n, oe_n;
  logic [15:0] addr_in;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = 16'h0;
  logic [15:0] dout;
  logic        dout_vld;
  logic        wait_o;
  logic        cur_rise;
  logic        mclk;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic        e_vld [0:NSTEP];
  logic [15:0] e_adr [0:NSTEP];

  always #4 clk = ~clk;

  burst_rd_seq u_burst_rd_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_word(cfg_word),
    .ce_n(ce_n), .le_n(le_n), .oe_n(oe_n), .addr_in(addr_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dout(dout), .dout_vld(dout_vld), .wait_o(wait_o)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a * 16'd37) ^ 16'h5A3C;
  endfunction

  // array model: registers the addressed word on the active edge
  assign mclk = cfg_word[6] ? clk : ~clk;
  always @(posedge mclk) if (mem_rd) mem_rdata <= memf(mem_addr);

  task automatic edge_wait();
    if (cur_rise) @(posedge clk); else @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: return "R4 wrap len4 unaligned";
      1: return "R4 linear len4";
      2: return "R5 hold2 len8 wrap";
      3: return "R7 low wait len16";
      4: return "R6 continuous gap";
      5: return "R6 R3 code000 continuous";
      6: return "R8 falling edge";
      7: return "R4 aligned wrap";
      default: return "R2 latency code0";
    endcase
  endfunction

  task automatic build_exp(input logic [25:0] v);
    int lat, hold, len, s, i;
    bit cont, lin, crossed;
    logic [15:0] a, na, m;
    lat  = int'(v[25:23]);
    if (lat < 2) lat = 2;
    hold = v[21] ? 2 : 1;
    lin  = v[19];
    cont = 1'b0; len = 0;
    case (v[18:16])
      3'b001: len = 4;
      3'b010: len = 8;
      3'b011: len = 16;
      default: cont = 1'b1;
    endcase
    s = 1;
    while (s < lat && s <= NSTEP) begin e_vld[s] = 1'b0; s++; end
    a = v[15:0]; i = 0; crossed = 1'b0;
    while (s <= NSTEP) begin
      for (int h = 0; h < hold && s <= NSTEP; h++) begin e_vld[s] = 1'b1; e_adr[s] = a; s++; end
      i++;
      if (!cont && i == len) begin
        while (s <= NSTEP) begin e_vld[s] = 1'b0; s++; end
      end else begin
        m = 16'(len - 1);
        na = (!cont && !lin) ? ((a & ~m) | ((a + 16'd1) & m)) : a + 16'd1;
        if (cont && !crossed && na[3:0] == 4'd0) begin
          if (s <= NSTEP) e_vld[s] = 1'b0;
          s++; crossed = 1'b1;
        end
        a = na;
      end
    end
  endtask

  task automatic run_vec(input logic [25:0] v, input string tag);
    logic ew, ok;
    logic [15:0] ed;
    ce_n = 1'b1; le_n = 1'b1; oe_n = 1'b0; clk_en = 1'b1;
    cfg_word = {2'b00, v[25:23], v[22], v[21], 2'b00, v[20], 2'b00, v[19], v[18:16]};
    cur_rise = v[20];
    edge_wait(); edge_wait(); #1;
    ce_n = 1'b0; le_n = 1'b0; addr_in = v[15:0];
    edge_wait(); #1;
    le_n = 1'b1;
    build_exp(v);
    for (int k = 1; k <= NSTEP; k++) begin
      edge_wait(); #3;
      ew = v[22] ? ~e_vld[k] : e_vld[k];
      ed = e_vld[k] ? memf(e_adr[k]) : dout;
      ok = (dout_vld == e_vld[k]) && (wait_o == ew) && (dout == ed);
      chk(ok, tag, {14'd0, dout_vld, wait_o, dout}, {14'd0, e_vld[k], ew, ed});
    end
    ce_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; ce_n = 1'b1; le_n = 1'b1; oe_n = 1'b0;
    addr_in = 16'h0; cur_rise = 1'b1;
    cfg_word = {2'b00, 3'd2, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 3'b001};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    edge_wait(); edge_wait(); #3;
    // R1 reset state
    chk(!dout_vld && !mem_rd && !wait_o, "R1 reset state",
        {29'd0, dout_vld, mem_rd, wait_o}, 32'd0);

    for (int vi = 0; vi < NVEC; vi++) run_vec(VEC[vi], tag_of(vi));

    // R9 suspend during latency and during data, R10 bus release, R12 fetch
    cur_rise = 1'b1; oe_n = 1'b0; clk_en = 1'b1;
    cfg_word = {2'b00, 3'd2, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 3'b001};
    edge_wait(); #1;
    ce_n = 1'b0; le_n = 1'b0; addr_in = 16'h0041;
    edge_wait(); #1;
    le_n = 1'b1; clk_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      edge_wait(); #3;
      chk(!dout_vld && wait_o && !mem_rd, "R9 frozen in latency",
          {29'd0, dout_vld, wait_o, mem_rd}, 32'd2);
    end
    clk_en = 1'b1;
    edge_wait(); #3;
    chk(mem_rd && mem_addr == 16'h0041 && !dout_vld, "R12 fetch before first word",
        {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'h0041});
    edge_wait(); #3;
    chk(dout_vld && !wait_o && dout == memf(16'h0041), "R9 first word after latency pause",
        {15'd0, dout_vld, dout}, {15'd0, 1'b1, memf(16'h0041)});
    clk_en = 1'b0; oe_n = 1'b1;
    edge_wait(); #3;
    chk(!dout_vld && dout == 16'h0 && !mem_rd, "R10 bus released while suspended",
        {15'd0, dout_vld, dout}, 32'd0);
    edge_wait(); #3;
    oe_n = 1'b0; #1;
    edge_wait(); #2;
    chk(dout_vld && dout == memf(16'h0041), "R9 word retained across suspend",
        {15'd0, dout_vld, dout}, {15'd0, 1'b1, memf(16'h0041)});
    clk_en = 1'b1;
    edge_wait(); #3;
    chk(dout_vld && dout == memf(16'h0042), "R9 resume at next word",
        {15'd0, dout_vld, dout}, {15'd0, 1'b1, memf(16'h0042)});
    edge_wait(); #3;
    chk(dout == memf(16'h0043), "R9 resume sequence", {16'd0, dout}, {16'd0, memf(16'h0043)});
    edge_wait(); #3;
    chk(dout_vld && dout == memf(16'h0040), "R4 wrap after resume",
        {15'd0, dout_vld, dout}, {15'd0, 1'b1, memf(16'h0040)});
    edge_wait(); #3;
    chk(!dout_vld && wait_o, "R3 end of burst holds wait",
        {30'd0, dout_vld, wait_o}, 32'd1);
    ce_n = 1'b1;
    edge_wait(); #3;
    chk(!wait_o && !dout_vld, "R11 deselect closes burst", {30'd0, dout_vld, wait_o}, 32'd0);

    // R10 sequencing continues while output disabled, R11 mid-burst deselect
    cfg_word = {2'b00, 3'd2, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 3'b001};
    edge_wait(); #1;
    ce_n = 1'b0; le_n = 1'b0; addr_in = 16'h0080;
    edge_wait(); #1;
    le_n = 1'b1;
    edge_wait(); edge_wait(); #3;
    chk(dout_vld && dout == memf(16'h0080), "R2 first word at latency 2",
        {15'd0, dout_vld, dout}, {15'd0, 1'b1, memf(16'h0080)});
    oe_n = 1'b1;
    edge_wait(); #3;
    chk(!dout_vld && dout == 16'h0, "R10 output masked", {15'd0, dout_vld, dout}, 32'd0);
    oe_n = 1'b0;
    edge_wait(); #3;
    chk(dout_vld && dout == memf(16'h0082), "R10 burst advanced while masked",
        {15'd0, dout_vld, dout}, {15'd0, 1'b1, memf(16'h0082)});
    ce_n = 1'b1;
    edge_wait(); #3;
    chk(!dout_vld && !wait_o, "R11 mid-burst deselect", {30'd0, dout_vld, wait_o}, 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule